// File: doc/BRIEF.md
# Indirect Register Access Bridge

This bridge gives a 32-bit host access to a small, byte-wide register space on a slow target without mapping that space onto the host bus. The host sets up a transfer through a control word that holds the target address, a direction bit, a size bit and byte enables. It then either writes the lower data register, which starts a target write, or writes a control word with the direction bit set, which starts a target read. A busy flag in the control word stays high for the whole transfer. When busy clears after a read, the target byte is in the lower data register.

On the target side there is a single request/acknowledge handshake with one address byte, one data byte in each direction and a write strobe. The request stays high, with its address and data held steady, until the target acknowledges. While a transfer is in flight, the host cannot change the control word or the lower data register.

The block also carries an interrupt enable register and an interrupt flag register. Flag bit 0 is set when a transfer completes and flag bit 1 is set by the target's interrupt line. The flags are cleared by writing 1 to them, and the host interrupt output is driven from the flags that are enabled.

Top module: `ibr_bridge`

## Requirements
- R1: A host read of offset 0x00 returns the parameter ID_VALUE. Host writes to offset 0x00 change nothing.
- R2: A host read of the control word at offset 0x04 returns the following fields. Bit 31 is the busy flag. Bit 25 is the stored size bit and bit 24 the stored direction bit. Bits 23:16 are the stored byte enables and bits 7:0 the stored target address. Every other bit reads 0, and bit 31 cannot be written.
- R3: A host write to the lower data register at offset 0x08 while the stored direction bit is 0 and the bridge is idle starts one target write. That write carries t_we=1, t_addr equal to the stored control bits 7:0, and t_wdata equal to bits 7:0 of the written word.
- R4: A host write to the control word with bit 24 set while the bridge is idle starts one target read at address bits 7:0 of that word. On acknowledge, the lower data register becomes {24'h0, t_rdata}.
- R5: Busy and t_req rise on the clock edge that starts a transfer. t_req stays high, with t_addr stable, until a cycle in which t_ack is high. In the cycle after that, t_req and busy are low.
- R6: Host writes to the control word or the lower data register while busy is set are ignored. They change no stored field and start no transfer.
- R7: The upper data register at offset 0x0C is a plain 32-bit register that the host can read and write.
- R8: The interrupt flag register at offset 0x14 works as follows. Bit 0 is set by each completed transfer and bit 1 by any cycle with t_irq high. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. The enable register at offset 0x10 is read/write in bits 1:0.
- R9: The output irq is high one cycle after (flag & enable) is nonzero, and low while no enabled flag is set.
- R10: Reset clears the control fields, both data registers, the enables and the flags, and drives t_req and irq low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | HA_W | Host register byte offset |
| h_wen | input | 1 | Host write strobe |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Registered host read data for the offset presented one cycle earlier |
| t_req | output | 1 | Target transfer request |
| t_we | output | 1 | Target write strobe (1 = write, 0 = read) |
| t_addr | output | 8 | Target register address |
| t_wdata | output | 8 | Target write data |
| t_rdata | input | 8 | Target read data, valid with t_ack |
| t_ack | input | 1 | Target acknowledge |
| t_irq | input | 1 | Target interrupt request |
| irq | output | 1 | Host interrupt output |

## Verification
Each possible internal fault shows up at a specific point.
- A sequencer that drops or holds its request wrongly is seen at the target port within one cycle of the acknowledge. It also shows as a busy flag that never clears when the host polls the control word.
- A wrongly latched address or data byte lands in the wrong location of the bench's target model. The full sweep of all 256 target addresses, written and then read back through the bridge, exposes this.
- A missing guard against writes while busy surfaces as an extra target access or a changed control word as soon as the transfer ends.
- Flag and mask faults appear on irq one cycle after the flag changes.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int unsigned OFS_ID   = 'h00;
  localparam int unsigned OFS_CTRL = 'h04;
  localparam int unsigned OFS_LDAT = 'h08;
  localparam int unsigned OFS_UDAT = 'h0C;
  localparam int unsigned OFS_IEN  = 'h10;
  localparam int unsigned OFS_IFLG = 'h14;

  localparam int unsigned CB_BUSY = 31;
  localparam int unsigned CB_SIZE = 25;
  localparam int unsigned CB_DIR  = 24;
  localparam int unsigned CB_BEHI = 23;
  localparam int unsigned CB_BELO = 16;

  localparam int unsigned TA_W = 8;
  localparam int unsigned TD_W = 8;

  typedef struct packed {
    logic            size;
    logic            dir;
    logic [7:0]      be;
    logic [TA_W-1:0] addr;
  } ctrl_t;

  typedef enum logic {SQ_IDLE, SQ_WAIT} seq_st_t;
endpackage

// File: rtl/ibr_seq.sv
module ibr_seq
  import ibr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic            launch_we,
  input  logic [TA_W-1:0] launch_addr,
  input  logic [TD_W-1:0] launch_data,
  input  logic            t_ack,
  output logic            busy,
  output logic            t_req,
  output logic            t_we,
  output logic [TA_W-1:0] t_addr,
  output logic [TD_W-1:0] t_wdata,
  output logic            xfer_done,
  output logic            rd_done
);
  seq_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      t_we    <= 1'b0;
      t_addr  <= '0;
      t_wdata <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (launch) begin
          st      <= SQ_WAIT;
          t_we    <= launch_we;
          t_addr  <= launch_addr;
          t_wdata <= launch_data;
        end
        SQ_WAIT: if (t_ack) st <= SQ_IDLE;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (st == SQ_WAIT);
  assign t_req     = (st == SQ_WAIT);
  assign xfer_done = (st == SQ_WAIT) && t_ack;
  assign rd_done   = xfer_done && !t_we;
endmodule

// File: rtl/ibr_irq.sv
module ibr_irq
  import ibr_pkg::*;
#(
  parameter int HA_W  = 5,
  parameter int IRQ_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             h_wen,
  input  logic [HA_W-1:0]  h_addr,
  input  logic [IRQ_N-1:0] h_wbits,
  input  logic [IRQ_N-1:0] set_ev,
  output logic [IRQ_N-1:0] flag,
  output logic [IRQ_N-1:0] en,
  output logic             irq
);
  logic wr_en, wr_flg;
  assign wr_en  = h_wen && (h_addr == HA_W'(OFS_IEN));
  assign wr_flg = h_wen && (h_addr == HA_W'(OFS_IFLG));

  for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        flag[i] <= 1'b0;
        en[i]   <= 1'b0;
      end else begin
        if (set_ev[i])                    flag[i] <= 1'b1;
        else if (wr_flg && h_wbits[i])    flag[i] <= 1'b0;
        if (wr_en)                        en[i]   <= h_wbits[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flag & en);
  end
endmodule

// File: rtl/ibr_host_regs.sv
module ibr_host_regs
  import ibr_pkg::*;
#(
  parameter int          HA_W     = 5,
  parameter int          IRQ_N    = 2,
  parameter logic [31:0] ID_VALUE = 32'h1B2D_0001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HA_W-1:0]  h_addr,
  input  logic             h_wen,
  input  logic [31:0]      h_wdata,
  output logic [31:0]      h_rdata,
  input  logic             busy,
  input  logic             rd_done,
  input  logic [TD_W-1:0]  rd_byte,
  input  logic [IRQ_N-1:0] flag,
  input  logic [IRQ_N-1:0] en,
  output ctrl_t            ctrl,
  output logic             launch,
  output logic             launch_we,
  output logic [TA_W-1:0]  launch_addr,
  output logic [TD_W-1:0]  launch_data
);
  logic [31:0] ldat, udat;
  logic wr_ctrl, wr_ldat, wr_udat, go_rd, go_wr;

  assign wr_ctrl = h_wen && (h_addr == HA_W'(OFS_CTRL));
  assign wr_ldat = h_wen && (h_addr == HA_W'(OFS_LDAT));
  assign wr_udat = h_wen && (h_addr == HA_W'(OFS_UDAT));

  assign go_rd       = wr_ctrl && h_wdata[CB_DIR] && !busy;
  assign go_wr       = wr_ldat && !ctrl.dir && !busy;
  assign launch      = go_rd || go_wr;
  assign launch_we   = go_wr;
  assign launch_addr = go_rd ? h_wdata[TA_W-1:0] : ctrl.addr;
  assign launch_data = h_wdata[TD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      ldat <= '0;
      udat <= '0;
    end else begin
      if (wr_ctrl && !busy)
        ctrl <= '{size: h_wdata[CB_SIZE], dir: h_wdata[CB_DIR],
                  be: h_wdata[CB_BEHI:CB_BELO], addr: h_wdata[TA_W-1:0]};
      if (rd_done)
        ldat <= {{(32-TD_W){1'b0}}, rd_byte};
      else if (wr_ldat && !busy)
        ldat <= h_wdata;
      if (wr_udat)
        udat <= h_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) h_rdata <= '0;
    else begin
      case (h_addr)
        HA_W'(OFS_ID):   h_rdata <= ID_VALUE;
        HA_W'(OFS_CTRL): h_rdata <= {busy, 5'b0, ctrl.size, ctrl.dir, ctrl.be,
                                     {(16-TA_W){1'b0}}, ctrl.addr};
        HA_W'(OFS_LDAT): h_rdata <= ldat;
        HA_W'(OFS_UDAT): h_rdata <= udat;
        HA_W'(OFS_IEN):  h_rdata <= {{(32-IRQ_N){1'b0}}, en};
        HA_W'(OFS_IFLG): h_rdata <= {{(32-IRQ_N){1'b0}}, flag};
        default:         h_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int          HA_W     = 5,
  parameter logic [31:0] ID_VALUE = 32'h1B2D_0001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HA_W-1:0] h_addr,
  input  logic            h_wen,
  input  logic [31:0]     h_wdata,
  output logic [31:0]     h_rdata,
  output logic            t_req,
  output logic            t_we,
  output logic [7:0]      t_addr,
  output logic [7:0]      t_wdata,
  input  logic [7:0]      t_rdata,
  input  logic            t_ack,
  input  logic            t_irq,
  output logic            irq
);
  localparam int IRQ_N = 2;

  ctrl_t            ctrl;
  logic             busy, launch, launch_we, xfer_done, rd_done;
  logic [TA_W-1:0]  launch_addr, ctrl_addr;
  logic [TD_W-1:0]  launch_data;
  logic [IRQ_N-1:0] flag, irq_en;

  assign ctrl_addr = ctrl.addr;

  ibr_host_regs #(.HA_W(HA_W), .IRQ_N(IRQ_N), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst(rst), .h_addr(h_addr), .h_wen(h_wen), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .busy(busy), .rd_done(rd_done), .rd_byte(t_rdata),
    .flag(flag), .en(irq_en), .ctrl(ctrl), .launch(launch),
    .launch_we(launch_we), .launch_addr(launch_addr), .launch_data(launch_data)
  );

  ibr_seq u_seq (
    .clk(clk), .rst(rst), .launch(launch), .launch_we(launch_we),
    .launch_addr(launch_addr), .launch_data(launch_data), .t_ack(t_ack),
    .busy(busy), .t_req(t_req), .t_we(t_we), .t_addr(t_addr),
    .t_wdata(t_wdata), .xfer_done(xfer_done), .rd_done(rd_done)
  );

  ibr_irq #(.HA_W(HA_W), .IRQ_N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst), .h_wen(h_wen), .h_addr(h_addr),
    .h_wbits(h_wdata[IRQ_N-1:0]), .set_ev({t_irq, xfer_done}),
    .flag(flag), .en(irq_en), .irq(irq)
  );
endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk
  import ibr_pkg::*;
#(
  parameter int          HA_W     = 5,
  parameter logic [31:0] ID_VALUE = 32'h1B2D_0001
) (
  input logic            clk,
  input logic            rst,
  input logic [HA_W-1:0] h_addr,
  input logic            h_wen,
  input logic [31:0]     h_rdata,
  input logic            t_req,
  input logic            t_ack,
  input logic [7:0]      t_addr,
  input logic            irq,
  input logic            busy,
  input logic [7:0]      ctrl_addr,
  input logic [1:0]      irq_en
);
  assert_id_const_R1: assert property (@(posedge clk) disable iff (rst)
    (h_addr == HA_W'(OFS_ID)) |=> (h_rdata == ID_VALUE));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (t_req && !t_ack) |=> (t_req && $stable(t_addr)));

  assert_req_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (t_req && t_ack) |=> !t_req);

  assert_busy_guard_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && h_wen && h_addr == HA_W'(OFS_CTRL)) |=> $stable(ctrl_addr));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_en == 2'b00) |=> !irq);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!t_req && !irq));
endmodule

bind ibr_bridge ibr_bridge_chk #(.HA_W(HA_W), .ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rst(rst), .h_addr(h_addr), .h_wen(h_wen), .h_rdata(h_rdata),
  .t_req(t_req), .t_ack(t_ack), .t_addr(t_addr), .irq(irq), .busy(busy),
  .ctrl_addr(ctrl_addr), .irq_en(irq_en)
);

// File: tb/test_ibr_bridge.sv
module test_ibr_bridge;
  localparam int          HA_W = 5;
  localparam logic [31:0] IDV  = 32'h1B2D_0001;
  localparam logic [4:0] A_ID = 5'h00, A_CTRL = 5'h04, A_LDAT = 5'h08,
                         A_UDAT = 5'h0C, A_IEN = 5'h10, A_IFLG = 5'h14;

  logic clk = 0, rst = 1;
  logic [HA_W-1:0] h_addr = '0;
  logic h_wen = 0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic t_req, t_we, t_ack = 0, t_irq = 0, irq;
  logic [7:0] t_addr, t_wdata, t_rdata = '0;

  int checks = 0, errors = 0, lat = 0, acks = 0;
  logic [7:0] tmem [256];

  always #10 clk = ~clk;

  ibr_bridge #(.HA_W(HA_W), .ID_VALUE(IDV)) i_ibr_bridge (
    .clk(clk), .rst(rst), .h_addr(h_addr), .h_wen(h_wen), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .t_req(t_req), .t_we(t_we), .t_addr(t_addr),
    .t_wdata(t_wdata), .t_rdata(t_rdata), .t_ack(t_ack), .t_irq(t_irq),
    .irq(irq));

  // target model: acknowledges after lat wait cycles
  initial begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < 256; i++) tmem[i] = 8'h5A;
    forever begin
      @(negedge clk);
      if (t_ack) t_ack = 0;
      else if (t_req) begin
        if (cnt >= lat) begin
          if (t_we) tmem[t_addr] = t_wdata;
          t_rdata = tmem[t_addr];
          t_ack = 1;
          acks++;
          cnt = 0;
        end else cnt++;
      end else cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_wdata = d; h_wen = 1;
    @(negedge clk);
    h_wen = 0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_wen = 0;
    @(negedge clk);
    d = h_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 60; k++) begin
      hr(A_CTRL, d);
      if (!d[31]) return;
    end
    chk(0, "R5 busy never cleared", d, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog expired actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  initial begin
    logic [31:0] d;
    int a0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R10 reset state
    chk(!t_req && !irq, "R10 outputs after reset", {30'b0, t_req, irq}, 0);
    hr(A_CTRL, d); chk(d == 0, "R10 ctrl reset", d, 0);
    hr(A_LDAT, d); chk(d == 0, "R10 ldat reset", d, 0);
    hr(A_UDAT, d); chk(d == 0, "R10 udat reset", d, 0);
    hr(A_IEN,  d); chk(d == 0, "R10 enable reset", d, 0);
    hr(A_IFLG, d); chk(d == 0, "R10 flag reset", d, 0);

    // R1 identification
    hr(A_ID, d); chk(d == IDV, "R1 id value", d, IDV);
    hw(A_ID, 32'hFFFF_FFFF);
    hr(A_ID, d); chk(d == IDV, "R1 id after write", d, IDV);

    // R2 field layout, reserved bits and busy not writable
    hw(A_CTRL, 32'hFE3F_FFA5);
    hr(A_CTRL, d); chk(d == 32'h023F_00A5, "R2 ctrl fields", d, 32'h023F_00A5);
    chk(acks == 0, "R2 no launch with dir=0", acks, 0);

    // R3 write sweep over all target addresses with varied latency
    for (int a = 0; a < 256; a++) begin
      lat = a % 4;
      hw(A_CTRL, 32'h0001_0000 | a);
      hw(A_LDAT, 32'hAB00_0000 | (a << 8) | pat(a));
      wait_idle();
      chk(tmem[a] == pat(a), "R3 target write byte", tmem[a], pat(a));
    end
    chk(acks == 256, "R3 one access per write", acks, 256);

    // R4 read sweep: ldat holds zero-extended byte
    for (int a = 0; a < 256; a++) begin
      lat = (a / 4) % 4;
      hw(A_CTRL, 32'h0101_0000 | a);
      wait_idle();
      hr(A_LDAT, d);
      chk(d == {24'h0, pat(a)}, "R4 read data", d, {24'h0, pat(a)});
    end

    // R5 busy visible during a slow transfer
    lat = 5;
    hw(A_CTRL, 32'h0101_0007);
    hr(A_CTRL, d); chk(d[31] == 1'b1, "R5 busy during transfer", d, 32'h8101_0007);
    wait_idle();
    hr(A_CTRL, d); chk(d == 32'h0101_0007, "R5 busy cleared", d, 32'h0101_0007);

    // R6 writes while busy are ignored
    lat = 8;
    hw(A_CTRL, 32'h0001_0010);
    a0 = acks;
    hw(A_LDAT, 32'h0000_0011);
    hw(A_CTRL, 32'h0101_0020);
    hw(A_LDAT, 32'h0000_0099);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(acks == a0 + 1, "R6 single access", acks, a0 + 1);
    hr(A_CTRL, d); chk(d == 32'h0001_0010, "R6 ctrl unchanged", d, 32'h0001_0010);
    hr(A_LDAT, d); chk(d == 32'h11, "R6 ldat unchanged", d, 32'h11);
    chk(tmem[16] == 8'h11, "R6 target byte written", tmem[16], 8'h11);
    chk(tmem[32] == pat(32), "R6 other byte untouched", tmem[32], pat(32));

    // R7 upper data storage
    hw(A_UDAT, 32'hDEAD_BEEF);
    hr(A_UDAT, d); chk(d == 32'hDEAD_BEEF, "R7 udat", d, 32'hDEAD_BEEF);
    hw(A_UDAT, 32'h1234_5678);
    hr(A_UDAT, d); chk(d == 32'h1234_5678, "R7 udat rewrite", d, 32'h1234_5678);

    // R8 / R9 flags and interrupt output
    lat = 1;
    hr(A_IFLG, d); chk(d == 32'h1, "R8 completion flag set", d, 1);
    chk(irq == 0, "R9 masked irq low", irq, 0);
    hw(A_IFLG, 32'h0);
    hr(A_IFLG, d); chk(d == 32'h1, "R8 write 0 keeps flag", d, 1);
    hw(A_IEN, 32'h1);
    hr(A_IEN, d); chk(d == 32'h1, "R8 enable readback", d, 1);
    @(negedge clk); chk(irq == 1, "R9 irq on enabled flag", irq, 1);
    hw(A_IFLG, 32'h1);
    @(negedge clk); chk(irq == 0, "R9 irq after clear", irq, 0);
    hr(A_IFLG, d); chk(d == 32'h0, "R8 w1c clears", d, 0);
    @(negedge clk); t_irq = 1;
    @(negedge clk); t_irq = 0;
    hr(A_IFLG, d); chk(d == 32'h2, "R8 target irq flag", d, 2);
    chk(irq == 0, "R9 bit1 masked", irq, 0);
    hw(A_IEN, 32'h2);
    @(negedge clk); chk(irq == 1, "R9 bit1 enabled", irq, 1);
    hw(A_CTRL, 32'h0101_0003);
    wait_idle();
    hr(A_IFLG, d); chk(d == 32'h3, "R8 both flags", d, 3);
    hw(A_IFLG, 32'h2);
    hr(A_IFLG, d); chk(d == 32'h1, "R8 clear bit1 only", d, 1);
    @(negedge clk); chk(irq == 0, "R9 irq low bit0 masked", irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule